// File: doc/BRIEF.md
# Scatter List to Descriptor Table Converter

This block turns a list of physically contiguous memory segments into the descriptor table that a bus-master disk DMA engine walks. Each segment is a 32-bit byte address and a 32-bit byte length. Segments arrive one at a time on a valid/ready stream, and a flag marks the last segment of a list. The block cuts every segment into pieces that never cross a 64 KiB address boundary. It writes one 8-byte entry per piece into a descriptor memory through an indexed write port. Each entry is an address word plus a count/flag word. At the end of the list it raises a one-cycle done pulse that carries the number of entries and a completion status.

Two count encodings are chosen by `altMode`, which must be held constant for the whole of a list:
- Normal encoding: the low 16 bits of the piece length, with bit 31 of the final entry's count word set as an end-of-table marker.
- Alternate encoding: a word-count form that has no end marker.

Any failure aborts the list. The remaining segments of that list are then accepted and discarded, so software can fall back to programmed I/O. The failures are:
- Overflow: the memory would need more than its capacity of entries.
- Misalignment: a segment breaks the alignment the encoding needs.

Top module: `prd_builder`

## Requirements
- R1: A piece starting at address A with R bytes left has length min(R, 0x10000 - A[15:0]). After each piece the address grows by that length and R shrinks by it, so no entry spans a 64 KiB boundary.
- R2: With `altMode`=0 the count word holds the piece length in bits 15:0, so a full 64 KiB piece reads 0. Bits 30:16 are zero.
- R3: With `altMode`=0 the final entry of a successful list has bit 31 of its count word set, and every other entry has it clear. This holds also when the list is ended by a zero-length segment after entries were written.
- R4: With `altMode`=1 the count word is ((length >> 2) - 1) in bits 31:16, bits 15:0 are zero, and no end marker is set.
- R5: The memory holds MAX_ENTRIES (256) entries. Needing one more aborts the list with `doneStatus`=2 (overflow), and `doneCount` equals MAX_ENTRIES.
- R6: A zero-length segment ends the list. If no entry was written, the done pulse reports `doneStatus`=1 (empty) and `doneCount`=0.
- R7: A segment with address bit 0 or length bit 0 set (`altMode`=0), or with address bits 1:0 or length bits 1:0 non-zero (`altMode`=1), aborts the list with `doneStatus`=3 (alignment).
- R8: Entries are written at indices 0, 1, 2, … in order, at most one per clock. The entry address word is the piece's start address. `segReady` is low while a segment is being split.
- R9: `done` is high for one cycle per list. On success `doneStatus`=0 and `doneCount` is the number of entries. After an abort, the segments up to and including the one with `segLast` are consumed without writes, and the next list starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altMode | input | 1 | 0 = normal encoding, 1 = alternate encoding |
| segValid | input | 1 | Segment present |
| segReady | output | 1 | Block accepts a segment this cycle |
| segAddr | input | 32 | Segment start byte address |
| segLen | input | 32 | Segment length in bytes |
| segLast | input | 1 | Segment is the last of its list |
| descWrEn | output | 1 | Descriptor write strobe |
| descWrIdx | output | 8 | Entry index written |
| descWrAddr | output | 32 | Entry address word |
| descWrCount | output | 32 | Entry count/flag word |
| done | output | 1 | One-cycle end-of-list pulse |
| doneCount | output | 9 | Entries in the table, valid with done |
| doneStatus | output | 2 | 0 ok, 1 empty, 2 overflow, 3 alignment |

## Verification
Some properties are checked on every cycle by assertions:
- every piece stays within its 64 KiB window;
- the unused bits of the count word stay zero in both encodings;
- the entry count never exceeds capacity;
- no segment is accepted while a write is in progress;
- `done` is a single-cycle pulse;
- an empty report comes with a zero count.

Other behaviours are shown only by the bench's scenarios, each compared against an arithmetic model of the whole table:
- the exact split points and encoded words;
- the end marker landing on the right entry, including the rewrite after a zero-length terminator;
- the overflow limit at exactly one entry past capacity;
- the discarding of a failed list's tail.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_EMPTY    = 2'd1,
    ST_OVERFLOW = 2'd2,
    ST_ALIGN    = 2'd3
  } doneStatus_e;

  typedef struct packed {
    logic loadSeg;
    logic stepChunk;
    logic patchLast;
    logic clrCnt;
  } prdStrobes_t;
endpackage

// File: rtl/prd_datapath.sv
module prd_datapath
  import prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  parameter int IDX_W = $clog2(MAX_ENTRIES),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             altMode,
  input  logic [31:0]      segAddr,
  input  logic [31:0]      segLen,
  input  logic             segLast,
  input  prdStrobes_t      strb,
  output logic             chunkTail,
  output logic             cntFull,
  output logic             cntZero,
  output logic             inMisaligned,
  output logic             inLenZero,
  output logic             segIsLast,
  output logic [IDX_W-1:0] wrIdx,
  output logic [31:0]      wrAddr,
  output logic [31:0]      wrCount,
  output logic [CNT_W-1:0] entryCnt
);
  localparam logic [16:0] WINDOW = 17'h10000;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENTRIES);

  logic [31:0]      curAddr, remLen, lastAddr, lastWord;
  logic [CNT_W-1:0] cnt;
  logic             segIsLastQ;
  logic [16:0]      room, chunk17;
  logic [31:0]      chunk32, pieceWord;
  logic [15:0]      altCnt;
  logic             isFinal;
  logic [CNT_W-1:0] cntPrev;

  // Bytes left before the next 64 KiB boundary; the piece is the smaller
  // of that room and what remains of the segment.
  always_comb begin
    room      = WINDOW - {1'b0, curAddr[15:0]};
    chunkTail = remLen <= {15'd0, room};
    chunk17   = chunkTail ? remLen[16:0] : room;
    chunk32   = {15'd0, chunk17};
    isFinal   = segIsLastQ & chunkTail;
    altCnt    = {1'b0, chunk17[16:2]} - 16'd1;
    if (altMode) pieceWord = {altCnt, 16'h0000};
    else         pieceWord = {isFinal, 15'd0, chunk17[15:0]};
  end

  always_comb begin
    cntPrev = cnt - CNT_W'(1);
    if (strb.patchLast) begin
      wrIdx   = cntPrev[IDX_W-1:0];
      wrAddr  = lastAddr;
      wrCount = lastWord | 32'h8000_0000;
    end else begin
      wrIdx   = cnt[IDX_W-1:0];
      wrAddr  = curAddr;
      wrCount = pieceWord;
    end
  end

  assign inMisaligned = altMode ? (|{segAddr[1:0], segLen[1:0]})
                                : (segAddr[0] | segLen[0]);
  assign inLenZero = (segLen == 32'd0);
  assign cntFull   = (cnt == CNT_MAX);
  assign cntZero   = (cnt == '0);
  assign segIsLast = segIsLastQ;
  assign entryCnt  = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr    <= '0;
      remLen     <= '0;
      lastAddr   <= '0;
      lastWord   <= '0;
      cnt        <= '0;
      segIsLastQ <= 1'b0;
    end else begin
      if (strb.loadSeg) begin
        curAddr    <= segAddr;
        remLen     <= segLen;
        segIsLastQ <= segLast;
      end else if (strb.stepChunk) begin
        curAddr  <= curAddr + chunk32;
        remLen   <= remLen - chunk32;
        lastAddr <= curAddr;
        lastWord <= pieceWord;
      end
      if (strb.clrCnt)         cnt <= '0;
      else if (strb.stepChunk) cnt <= cnt + CNT_W'(1);
    end
  end

  // R1: a written piece never runs past its 64 KiB window
  a_r1_no_cross: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepChunk |-> ({1'b0, curAddr[15:0]} + chunk17) <= {1'b0, WINDOW});
  // R2: normal encoding leaves bits 30:16 clear
  a_r2_norm_upper: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepChunk && !altMode) |-> (wrCount[30:16] == 15'd0));
  // R4: alternate encoding never carries the end marker
  a_r4_alt_no_end: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepChunk && altMode) |-> (!wrCount[31] && wrCount[15:0] == 16'd0));
  // R5: the entry count stays within capacity
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);
endmodule

// File: rtl/prd_control.sv
module prd_control
  import prd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        altMode,
  input  logic        segValid,
  input  logic        segLast,
  input  logic        chunkTail,
  input  logic        cntFull,
  input  logic        cntZero,
  input  logic        inMisaligned,
  input  logic        inLenZero,
  input  logic        segIsLast,
  output logic        segReady,
  output prdStrobes_t strb,
  output logic        descWrEn,
  output logic        done,
  output doneStatus_e doneStatus
);
  typedef enum logic [1:0] {S_IDLE, S_SPLIT, S_PATCH, S_DRAIN} state_e;

  state_e      state, stateNext;
  logic        doneQ, doneNext, pendDrain, pendDrainNext;
  doneStatus_e statusQ, statusNext;
  logic        accept;

  assign segReady = (state == S_IDLE || state == S_DRAIN) && !doneQ;
  assign accept   = segValid && segReady;

  always_comb begin
    stateNext     = state;
    pendDrainNext = pendDrain;
    doneNext      = 1'b0;
    statusNext    = statusQ;
    strb          = '0;
    strb.clrCnt   = doneQ;
    unique case (state)
      S_IDLE: if (accept) begin
        if (inLenZero) begin
          if (cntZero) begin
            doneNext   = 1'b1;
            statusNext = ST_EMPTY;
            stateNext  = segLast ? S_IDLE : S_DRAIN;
          end else if (!altMode) begin
            stateNext     = S_PATCH;
            pendDrainNext = !segLast;
          end else begin
            doneNext   = 1'b1;
            statusNext = ST_OK;
            stateNext  = segLast ? S_IDLE : S_DRAIN;
          end
        end else if (inMisaligned) begin
          doneNext   = 1'b1;
          statusNext = ST_ALIGN;
          stateNext  = segLast ? S_IDLE : S_DRAIN;
        end else begin
          strb.loadSeg = 1'b1;
          stateNext    = S_SPLIT;
        end
      end
      S_SPLIT: begin
        if (cntFull) begin
          doneNext   = 1'b1;
          statusNext = ST_OVERFLOW;
          stateNext  = segIsLast ? S_IDLE : S_DRAIN;
        end else begin
          strb.stepChunk = 1'b1;
          if (chunkTail) begin
            stateNext = S_IDLE;
            if (segIsLast) begin
              doneNext   = 1'b1;
              statusNext = ST_OK;
            end
          end
        end
      end
      S_PATCH: begin
        strb.patchLast = 1'b1;
        doneNext       = 1'b1;
        statusNext     = ST_OK;
        stateNext      = pendDrain ? S_DRAIN : S_IDLE;
      end
      S_DRAIN: if (accept && segLast) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneQ     <= 1'b0;
      statusQ   <= ST_OK;
      pendDrain <= 1'b0;
    end else begin
      state     <= stateNext;
      doneQ     <= doneNext;
      statusQ   <= statusNext;
      pendDrain <= pendDrainNext;
    end
  end

  assign descWrEn   = strb.stepChunk | strb.patchLast;
  assign done       = doneQ;
  assign doneStatus = statusQ;

  // R8: no segment is taken while a descriptor is being written
  a_r8_no_accept_on_write: assert property (@(posedge clk) disable iff (!rstN)
    descWrEn |-> !segReady);
  // R9: done lasts exactly one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R6: an empty report only with no entries counted
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && statusQ == ST_EMPTY) |-> cntZero);
endmodule

// File: rtl/prd_builder.sv
module prd_builder
  import prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             altMode,
  input  logic             segValid,
  output logic             segReady,
  input  logic [31:0]      segAddr,
  input  logic [31:0]      segLen,
  input  logic             segLast,
  output logic             descWrEn,
  output logic [IDX_W-1:0] descWrIdx,
  output logic [31:0]      descWrAddr,
  output logic [31:0]      descWrCount,
  output logic             done,
  output logic [CNT_W-1:0] doneCount,
  output logic [1:0]       doneStatus
);
  prdStrobes_t strb;
  logic chunkTail, cntFull, cntZero, inMisaligned, inLenZero, segIsLast;
  doneStatus_e statusE;

  prd_datapath #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .altMode(altMode),
    .segAddr(segAddr), .segLen(segLen), .segLast(segLast), .strb(strb),
    .chunkTail(chunkTail), .cntFull(cntFull), .cntZero(cntZero),
    .inMisaligned(inMisaligned), .inLenZero(inLenZero), .segIsLast(segIsLast),
    .wrIdx(descWrIdx), .wrAddr(descWrAddr), .wrCount(descWrCount),
    .entryCnt(doneCount)
  );

  prd_control u_ctl (
    .clk(clk), .rstN(rstN), .altMode(altMode),
    .segValid(segValid), .segLast(segLast),
    .chunkTail(chunkTail), .cntFull(cntFull), .cntZero(cntZero),
    .inMisaligned(inMisaligned), .inLenZero(inLenZero), .segIsLast(segIsLast),
    .segReady(segReady), .strb(strb), .descWrEn(descWrEn),
    .done(done), .doneStatus(statusE)
  );

  assign doneStatus = statusE;
endmodule

// File: tb/sim_prd_builder.sv
module sim_prd_builder;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 256;

  logic clk = 1'b0, rstN = 1'b0;
  logic altMode = 1'b0, segValid = 1'b0, segLast = 1'b0;
  logic [31:0] segAddr = '0, segLen = '0;
  logic segReady, descWrEn, done;
  logic [7:0] descWrIdx;
  logic [31:0] descWrAddr, descWrCount;
  logic [8:0] doneCount;
  logic [1:0] doneStatus;

  int compared = 0, mismatched = 0, cycles = 0;

  logic [31:0] memA [MAXE], memC [MAXE];
  logic [31:0] expA [MAXE], expC [MAXE];
  logic [31:0] sA [16], sL [16];
  int sN, expN, expSt;
  logic doneSeen;
  int gotCount, gotStatus;

  always #(CLK_PERIOD/2) clk = ~clk;

  prd_builder u0 (
    .clk(clk), .rstN(rstN), .altMode(altMode), .segValid(segValid),
    .segReady(segReady), .segAddr(segAddr), .segLen(segLen), .segLast(segLast),
    .descWrEn(descWrEn), .descWrIdx(descWrIdx), .descWrAddr(descWrAddr),
    .descWrCount(descWrCount), .done(done), .doneCount(doneCount),
    .doneStatus(doneStatus)
  );

  always @(negedge clk) begin
    if (rstN && descWrEn) begin
      memA[descWrIdx] = descWrAddr;
      memC[descWrIdx] = descWrCount;
    end
    if (rstN && done) begin
      doneSeen  = 1'b1;
      gotCount  = int'(doneCount);
      gotStatus = int'(doneStatus);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      summary();
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Arithmetic model of the whole table from the requirements
  task automatic model();
    logic [31:0] a, r, room, b;
    logic bad;
    expN = 0; expSt = 0;
    for (int i = 0; i < sN; i++) begin
      if (sL[i] == 0) break;                                    // R6
      bad = altMode ? ((sA[i][1:0] != 0) || (sL[i][1:0] != 0))
                    : (sA[i][0] || sL[i][0]);
      if (bad) begin expSt = 3; return; end                     // R7
      a = sA[i]; r = sL[i];
      while (r != 0) begin
        if (expN == MAXE) begin expSt = 2; return; end          // R5
        room = 32'h10000 - {16'd0, a[15:0]};                    // R1
        b = (r < room) ? r : room;
        expA[expN] = a;
        expC[expN] = altMode ? ((((b >> 2) - 1) & 32'hFFFF) << 16)  // R4
                             : (b & 32'hFFFF);                      // R2
        expN++;
        a = a + b; r = r - b;
      end
    end
    if (expN == 0) expSt = 1;
    else if (!altMode) expC[expN-1] |= 32'h8000_0000;           // R3
  endtask

  task automatic sendSeg(logic [31:0] a, logic [31:0] l, logic last);
    segAddr = a; segLen = l; segLast = last; segValid = 1'b1;
    while (!segReady) @(negedge clk);
    @(negedge clk);
    segValid = 1'b0;
  endtask

  task automatic runList(string tag);
    for (int k = 0; k < MAXE; k++) begin memA[k] = 32'hDEAD_BEEF; memC[k] = 32'hDEAD_BEEF; end
    doneSeen = 1'b0;
    model();
    for (int i = 0; i < sN; i++) sendSeg(sA[i], sL[i], i == sN - 1);
    while (!doneSeen) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expSt == 0 ? "R9" : (expSt == 1 ? "R6" : (expSt == 2 ? "R5" : "R7")),
          {tag, " status"}, gotStatus, expSt);
    check(expSt == 2 ? "R5" : "R9", {tag, " count"}, gotCount, expN);
    for (int k = 0; k < expN; k++) begin
      check("R8", {tag, " addr word"}, memA[k], expA[k]);
      check(altMode ? "R4" : (k == expN - 1 ? "R3" : "R2"), {tag, " count word"},
            memC[k], expC[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset done", done, 0);
    check("R8", "reset wr", descWrEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "reset ready", segReady, 1);
    check("R9", "reset count", doneCount, 0);

    // R1 R2 R3: single small segment, then one crossing a boundary
    altMode = 0;
    sN = 1; sA[0] = 32'h0000_1000; sL[0] = 32'h200; runList("R2 small");
    sN = 1; sA[0] = 32'h0001_FF00; sL[0] = 32'h300; runList("R1 cross");
    // R2: full 64 KiB aligned piece encodes 0 with end bit
    sN = 1; sA[0] = 32'h0003_0000; sL[0] = 32'h10000; runList("R2 full");
    // R1: long segment spanning several windows
    sN = 1; sA[0] = 32'h0004_8000; sL[0] = 32'h28000; runList("R1 long");
    // R8: multiple segments
    sN = 3; sA[0] = 32'h100; sL[0] = 32'h40; sA[1] = 32'h5_FFFE; sL[1] = 32'h4;
    sA[2] = 32'h9000; sL[2] = 32'h10; runList("R8 multi");
    // R3: zero-length terminator after entries, tail drained
    sN = 4; sA[0] = 32'h2000; sL[0] = 32'h80; sA[1] = 32'h7_FFF0; sL[1] = 32'h20;
    sA[2] = 32'h0; sL[2] = 32'h0; sA[3] = 32'h4000; sL[3] = 32'h10; runList("R3 term");
    // R6: empty list
    sN = 1; sA[0] = 32'h1234; sL[0] = 32'h0; runList("R6 empty");
    // R7: misaligned length, then tail drained; next list must start at 0
    sN = 3; sA[0] = 32'h1000; sL[0] = 32'h10; sA[1] = 32'h2000; sL[1] = 32'h11;
    sA[2] = 32'h3000; sL[2] = 32'h10; runList("R7 odd len");
    sN = 1; sA[0] = 32'h3001; sL[0] = 32'h10; runList("R7 odd addr");
    sN = 1; sA[0] = 32'h8000; sL[0] = 32'h20; runList("R9 after abort");
    // R4: alternate encoding, boundary split, terminator without patch
    altMode = 1;
    sN = 1; sA[0] = 32'h0001_FFF0; sL[0] = 32'h40; runList("R4 alt cross");
    sN = 2; sA[0] = 32'h0002_0000; sL[0] = 32'h10000; sA[1] = 32'h0; sL[1] = 32'h0;
    runList("R4 alt full");
    sN = 1; sA[0] = 32'h1002; sL[0] = 32'h10; runList("R7 alt addr");
    sN = 1; sA[0] = 32'h1000; sL[0] = 32'h12; runList("R7 alt len");
    // R1 R2 R4: sweep of offsets near a boundary in both encodings
    for (int off = 0; off < 16; off++) begin
      altMode = off[0];
      sN = 2;
      sA[0] = 32'h0001_0000 - 32'd32 + 32'(off * 4); sL[0] = 32'd8 + 32'(off * 8);
      sA[1] = 32'h000F_FFFC - 32'(off * 4);           sL[1] = 32'd4 + 32'(off * 4);
      runList("R1 sweep");
    end
    // R5: exactly capacity succeeds, one more overflows
    altMode = 0;
    sN = 1; sA[0] = 32'h0; sL[0] = 32'h0100_0000; runList("R5 exact");
    sN = 2; sA[0] = 32'h0; sL[0] = 32'h0100_0000; sA[1] = 32'h10; sL[1] = 32'h2;
    runList("R5 over");
    sN = 1; sA[0] = 32'h0; sL[0] = 32'h0101_0000; runList("R5 over single");
    sN = 1; sA[0] = 32'h40; sL[0] = 32'h8; runList("R9 after overflow");
    summary();
  end
endmodule